// File: doc/BRIEF.md
# Free-Run Timer with Masked Compare Clear

This block is a free-running up-counter with a compare-clear register. On each count enable it adds one to the count. When the count already equals the compare-clear value, it returns the count to zero instead. The count enable comes from one of two sources, picked by a source-select bit. The first is an internal prescaled tick pulse supplied by the surrounding chip. The second is an external clock pin, which passes through a synchronizer and a rising-edge detector.

A small down-counter can hide a programmed number of compare-clear events before the interrupt flag is raised. The flag clears only when software writes 0 to it. During a read-modify-write access the flag reads as 1, so rewriting the other control bits cannot wipe out a pending event. The interrupt request is the flag gated by an enable bit.

Software reaches the block through a simple register port with three addresses: the control byte, the compare-clear value and the live count. Read data is registered.

Top module: `frt_clear_mask`

## Requirements
- R1: After a synchronous reset the following are all zero: the count, the compare value, the mask field, the flag, the enable bit, `irq_o` and the source-select bit (zero selects the internal tick).
- R2: On each count enable whose count differs from the compare value, the count increases by exactly one. Without a count enable the count holds its value.
- R3: On a count enable while the count equals the compare value, the count becomes 0. A compare value C therefore gives a period of C+1 enables.
- R4: The mask field is control bits 3:1. A value of N suppresses N compare-clear matches and raises the flag on match N+1. Each suppressed match lowers the field by one, and the lowered value is readable. A value of 0 masks nothing.
- R5: A control write loads the mask field from the written value and replaces any partly decremented count.
- R6: The flag is control bit 5. A control write with bit 5 at 0 clears it. A control write with bit 5 at 1 leaves it unchanged.
- R7: A read with `bus_rmw_i` high returns the flag bit as 1. A plain read returns the true flag.
- R8: When a compare-clear match with a zero mask field falls in the same cycle as a control write that clears the flag, the flag ends at 1.
- R9: `irq_o` is high exactly when the flag and the enable bit (control bit 4) are both 1. It is updated on the same edge as the flag.
- R10: Control bits 7:6 always read as 0, and writes to them change nothing.
- R11: Control bit 0 selects the count source: 0 selects `tick_i` and 1 selects `ext_clk_i`. In external mode each rising edge of `ext_clk_i` gives exactly one count enable, after two synchronizer flops and an edge detector. The source not selected has no effect on the count.
- R12: Address 0 selects control, 1 selects compare and 2 selects the count. The count address is read-only, so writes to it are ignored. Read data appears on `bus_rdata_o` the cycle after `bus_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Internal prescaled count pulse |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| bus_addr_i | input | 2 | Register select: 0 control, 1 compare, 2 count |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rmw_i | input | 1 | Marks the read half of a read-modify-write |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Registered read data |
| irq_o | output | 1 | Compare-clear interrupt request |

## Verification
The hardest case to reach from the ports is a compare-clear match landing in the same cycle as a software write that clears the flag. Only then does the hardware set have to win. The bench first rewrites the compare register to the count it is tracking, so the next tick is certain to match. It then raises the clear-write and the tick together in one cycle. The mask behaviour is swept over every mask value and several compare values, with the count brought back to zero before each step. Every step is checked against an arithmetic model kept in the bench.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int SRC_BIT = 0;
  localparam int MASK_LSB = 1;
endpackage

// File: rtl/frt_edge_sync.sv
module frt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             match
);
  assign match = cnt_en && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (match) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (cmp_wr) begin
      cmp_q <= cmp_wdata;
    end
  end
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl #(
  parameter int MASK_W = 3,
  localparam int IEN_BIT  = MASK_W + 1,
  localparam int FLAG_BIT = MASK_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [FLAG_BIT:0] ctrl_wdata,
  input  logic              match,
  output logic              src_ext_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              flag_q,
  output logic              ien_q,
  output logic              irq_q
);
  import frt_pkg::*;

  logic              flag_d;
  logic              ien_d;
  logic [MASK_W-1:0] mask_d;
  logic              src_d;
  logic              raise;

  assign raise = match && (mask_q == '0);

  always_comb begin
    src_d  = src_ext_q;
    ien_d  = ien_q;
    mask_d = mask_q;
    flag_d = flag_q;
    if (match && (mask_q != '0)) begin
      mask_d = mask_q - 1'b1;
    end
    if (ctrl_wr) begin
      src_d  = ctrl_wdata[SRC_BIT];
      ien_d  = ctrl_wdata[IEN_BIT];
      mask_d = ctrl_wdata[MASK_LSB +: MASK_W];
      if (!ctrl_wdata[FLAG_BIT]) begin
        flag_d = 1'b0;
      end
    end
    if (raise) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_ext_q <= 1'b0;
      ien_q     <= 1'b0;
      mask_q    <= '0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      src_ext_q <= src_d;
      ien_q     <= ien_d;
      mask_q    <= mask_d;
      flag_q    <= flag_d;
      irq_q     <= flag_d & ien_d;
    end
  end
endmodule

// File: rtl/frt_clear_mask.sv
module frt_clear_mask #(
  parameter int CNT_W       = 16,
  parameter int MASK_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ext_clk_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic             bus_rmw_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  import frt_pkg::*;

  localparam int IEN_BIT  = MASK_W + 1;
  localparam int FLAG_BIT = MASK_W + 2;

  reg_sel_e          sel;
  logic              ext_rise;
  logic              cnt_en;
  logic              match;
  logic              ctrl_wr;
  logic              cmp_wr;
  logic              src_ext_q;
  logic [MASK_W-1:0] mask_q;
  logic              flag_q;
  logic              ien_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  ctrl_word;
  logic [CNT_W-1:0]  rdata_q;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign ctrl_wr = bus_wr_i && (sel == SEL_CTRL);
  assign cmp_wr  = bus_wr_i && (sel == SEL_CMP);
  assign cnt_en  = src_ext_q ? ext_rise : tick_i;

  frt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  frt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (bus_wdata_i),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .match     (match)
  );

  frt_ctrl #(.MASK_W(MASK_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (bus_wdata_i[FLAG_BIT:0]),
    .match      (match),
    .src_ext_q  (src_ext_q),
    .mask_q     (mask_q),
    .flag_q     (flag_q),
    .ien_q      (ien_q),
    .irq_q      (irq_o)
  );

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[SRC_BIT]                 = src_ext_q;
    ctrl_word[MASK_LSB +: MASK_W]      = mask_q;
    ctrl_word[IEN_BIT]                 = ien_q;
    ctrl_word[FLAG_BIT]                = flag_q | bus_rmw_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      unique case (sel)
        SEL_CTRL: rdata_q <= ctrl_word;
        SEL_CMP:  rdata_q <= cmp_q;
        SEL_CNT:  rdata_q <= cnt_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/frt_clear_mask_chk.sv
module frt_clear_mask_chk #(
  parameter int CNT_W  = 16,
  parameter int MASK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              match,
  input logic              ctrl_wr,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [MASK_W-1:0] mask_q,
  input logic              flag_q,
  input logic              ien_q,
  input logic              irq_o
);
  // R2
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && (cnt_q != cmp_q)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));
  // R3
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && (cnt_q == cmp_q)) |=> (cnt_q == '0));
  // R4
  p_mask_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (match && (mask_q != '0) && !ctrl_wr) |=> (mask_q == MASK_W'($past(mask_q) - 1'b1)));
  // R8
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (match && (mask_q == '0)) |=> flag_q);
  // R9
  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_q && ien_q));
endmodule

bind frt_clear_mask frt_clear_mask_chk #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_en  (cnt_en),
  .match   (match),
  .ctrl_wr (ctrl_wr),
  .cnt_q   (cnt_q),
  .cmp_q   (cmp_q),
  .mask_q  (mask_q),
  .flag_q  (flag_q),
  .ien_q   (ien_q),
  .irq_o   (irq_o)
);

// File: tb/frt_clear_mask_bench.sv
module frt_clear_mask_bench;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         ext = 1'b0;
  logic [1:0]   addr = '0;
  logic         wr = 1'b0;
  logic         rd = 1'b0;
  logic         rmw = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int cnt_m = 0, cmp_m = 0, mask_m = 0, flag_m = 0, ien_m = 0, src_m = 0;

  always #(PERIOD/2) clk = ~clk;

  frt_clear_mask u_frt_clear_mask (
    .clk (clk), .rst (rst), .tick_i (tick), .ext_clk_i (ext),
    .bus_addr_i (addr), .bus_wr_i (wr), .bus_rd_i (rd), .bus_rmw_i (rmw),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
  );

  function automatic int mk(int s, int m, int ie, int f);
    return (s & 1) | ((m & 7) << 1) | ((ie & 1) << 4) | ((f & 1) << 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk); addr = 2'(a); wdata = W'(d); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(int a, bit m, output int d);
    @(negedge clk); addr = 2'(a); rd = 1'b1; rmw = m;
    @(negedge clk); rd = 1'b0; rmw = 1'b0; d = int'(rdata);
  endtask

  task automatic model_tick();
    if (cnt_m == cmp_m) begin
      cnt_m = 0;
      if (mask_m != 0) mask_m--; else flag_m = 1;
    end else cnt_m = (cnt_m + 1) & 16'hFFFF;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (src_m == 0) model_tick();
  endtask

  task automatic wr_ctrl(int s, int m, int ie, int f);
    wr_reg(0, mk(s, m, ie, f));
    src_m = s; mask_m = m; ien_m = ie;
    if (f == 0) flag_m = 0;
  endtask

  task automatic align();
    wr_reg(1, cnt_m); cmp_m = cnt_m;
    do_tick();
  endtask

  task automatic ext_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1;
      repeat (4) @(negedge clk);
      ext = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    int d;
    int cmps[3] = '{0, 2, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(0, 0, d); chk("R1 ctrl", d, 0);
    rd_reg(1, 0, d); chk("R1 cmp", d, 0);
    rd_reg(2, 0, d); chk("R1 cnt", d, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 R3 R4 R9 sweep over mask and compare values
    for (int m = 0; m < 8; m++) begin
      for (int ci = 0; ci < 3; ci++) begin
        align();
        wr_reg(1, cmps[ci]); cmp_m = cmps[ci];
        wr_ctrl(0, m, m & 1, 0);
        for (int k = 0; k < (m + 1) * (cmps[ci] + 1) + 1; k++) begin
          do_tick();
          chk("R9 irq", int'(irq), flag_m & ien_m);
          rd_reg(2, 0, d); chk("R2/R3 count", d, cnt_m);
          rd_reg(0, 0, d); chk("R4 ctrl", d, mk(0, mask_m, ien_m, flag_m));
        end
      end
    end

    // R6 R7 flag write and read-modify-write
    chk("R6 flag set before test", flag_m, 1);
    wr_ctrl(0, 0, 1, 1);
    rd_reg(0, 0, d); chk("R6 write 1 keeps", d, mk(0, 0, 1, 1));
    chk("R9 irq with flag and enable", int'(irq), 1);
    wr_ctrl(0, 0, 0, 1);
    chk("R9 irq masked by enable", int'(irq), 0);
    wr_ctrl(0, 0, 1, 0);
    rd_reg(0, 0, d); chk("R6 write 0 clears", d, mk(0, 0, 1, 0));
    wr_ctrl(0, 0, 1, 1);
    rd_reg(0, 0, d); chk("R6 write 1 on clear flag", d, mk(0, 0, 1, 0));
    rd_reg(0, 1, d); chk("R7 rmw read", d, mk(0, 0, 1, 1));
    rd_reg(0, 0, d); chk("R7 plain read", d, mk(0, 0, 1, 0));

    // R10 unused bits
    wr_reg(0, 32'hC0 | mk(0, 3, 0, 0)); src_m = 0; mask_m = 3; ien_m = 0; flag_m = 0;
    rd_reg(0, 0, d); chk("R10 unused bits", d, mk(0, 3, 0, 0));

    // R8 set beats clear in the same cycle
    wr_ctrl(0, 0, 1, 0);
    align();
    chk("R8 flag before", flag_m, 1);
    wr_reg(1, cnt_m); cmp_m = cnt_m;
    @(negedge clk); addr = 2'd0; wdata = W'(mk(0, 0, 1, 0)); wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    cnt_m = 0;
    rd_reg(0, 0, d); chk("R8 set wins", d, mk(0, 0, 1, 1));
    chk("R8 irq", int'(irq), 1);

    // R5 mask write replaces partial count
    wr_reg(1, 0); cmp_m = 0;
    wr_ctrl(0, 5, 0, 0);
    do_tick(); do_tick();
    rd_reg(0, 0, d); chk("R5 partial", d, mk(0, 3, 0, 0));
    wr_ctrl(0, 1, 0, 0);
    rd_reg(0, 0, d); chk("R5 reload", d, mk(0, 1, 0, 0));
    do_tick();
    rd_reg(0, 0, d); chk("R5 after one", d, mk(0, 0, 0, 0));
    do_tick();
    rd_reg(0, 0, d); chk("R5 flag raised", d, mk(0, 0, 0, 1));

    // R11 external source
    wr_reg(1, 1000); cmp_m = 1000;
    wr_ctrl(1, 0, 0, 0);
    do_tick(); do_tick(); do_tick();
    rd_reg(2, 0, d); chk("R11 tick ignored", d, cnt_m);
    ext_edges(5); cnt_m += 5;
    repeat (4) @(negedge clk);
    rd_reg(2, 0, d); chk("R11 ext edges", d, cnt_m);
    wr_ctrl(0, 0, 0, 0);
    ext_edges(3);
    repeat (4) @(negedge clk);
    rd_reg(2, 0, d); chk("R11 ext ignored", d, cnt_m);
    do_tick(); do_tick();
    rd_reg(2, 0, d); chk("R11 internal", d, cnt_m);

    // R12 map and read-only count
    wr_reg(2, 16'h1234);
    rd_reg(2, 0, d); chk("R12 count read-only", d, cnt_m);
    rd_reg(1, 0, d); chk("R12 compare", d, 1000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule